// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that gives a bus controller access to a 256-byte array inside the chip. SCL and SDA are brought into the system clock domain through two-flop synchronisers. START and STOP are found from SDA edges while SCL is high. The block answers only to its own 7-bit device address. SDA is driven open-drain: `sda_oe` high means the pad pulls the line low.

A single address pointer serves both reads and writes. It always points one past the byte most recently read or written, and it rolls over from 255 to 0.

A write transfer sends a word address and then any number of data bytes. A word address followed by a repeated START, or by a STOP, only moves the pointer. A read with R/W set returns bytes from the pointer for as long as the controller acknowledges them. This gives current-address, random and sequential reads with the same logic.

Top module: `i2c_mem_target`

## Requirements
- R1: A fall of SDA while SCL is high (START or repeated START) restarts address reception from any state. A rise of SDA while SCL is high (STOP) returns the block to idle with SDA released.
- R2: The block acknowledges only a device address whose upper 7 bits equal DEV_ADDR (default 7'h50). On a mismatch it leaves SDA released and ignores all bytes until the next START.
- R3: In a write (R/W bit, bit 0 of the address byte, equal to 0), the first byte after the device address loads the pointer. Each following byte is stored at the pointer, and the pointer then advances. Every received byte is acknowledged by pulling SDA low in the ninth clock.
- R4: A word address followed by a repeated START or a STOP modifies no memory location; it only sets the pointer.
- R5: A random read (a write of the device address and word address, then a repeated START and the device address with R/W = 1) returns the byte at that word address.
- R6: A current-address read returns the byte one past the last byte accessed, whether that access was a read or a write.
- R7: While the controller acknowledges each data byte, the block sends consecutive bytes. After a NACK it releases SDA and stays silent until the next START.
- R8: The pointer wraps from 255 to 0 in both reads and writes, and data stays correct across the wrap.
- R9: Data goes out MSB first, and the block changes `sda_oe` only while the synchronised SCL is low.
- R10: Reset releases SDA and clears the pointer to 0. It leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level (wired-AND bus value) |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
The checks assume that each SCL high and low phase lasts several system clocks longer than the three-cycle synchroniser and edge-detect delay. They also assume the controller changes SDA only while SCL is low, except when it makes a START or STOP, and never issues either of those while the target holds SDA low. The bench's controller tasks hold every SCL phase for ten clocks and move SDA in the middle of the low phase, so both inputs are settled whenever a synchronised edge is seen. A monitor counts any `sda_oe` change while SCL is high.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = 1;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_DEV = 3'd1, S_ACKD = 3'd2, S_WADR = 3'd3,
    S_WDAT = 3'd4, S_ACKW = 3'd5, S_RDAT = 3'd6, S_RACK = 3'd7
  } st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  st_t st;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic rw, mack;
  logic [AW-1:0] ptr;
  logic [7:0] mem [DEPTH];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_end = scl_fall && (bitcnt == 4'd8);
  wire wr_en = (st == S_WDAT) && byte_end && !start_c && !stop_c;
  wire [7:0] rd_byte = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  always_ff @(posedge clk)
    if (wr_en) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= 4'd0;
      sh     <= 8'd0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= S_DEV;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            bitcnt <= 4'd0;
            if (st == S_DEV) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                st     <= S_ACKD;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              ptr    <= (st == S_WADR) ? sh[AW-1:0] : ptr + ONE;
              sda_oe <= 1'b1;
              st     <= S_ACKW;
            end
          end
        end
        S_ACKD:
          if (scl_fall) begin
            if (rw) begin
              sh     <= rd_byte;
              ptr    <= ptr + ONE;
              sda_oe <= ~rd_byte[7];
              st     <= S_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WADR;
            end
          end
        S_ACKW:
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WDAT;
          end
        S_RDAT: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            sda_oe <= 1'b0;
            bitcnt <= 4'd0;
            st     <= S_RACK;
          end else if (scl_fall) begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              sh     <= rd_byte;
              ptr    <= ptr + ONE;
              sda_oe <= ~rd_byte[7];
              st     <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
endmodule

module i2c_mem_target_chk #(
  parameter int AW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_c,
  input logic stop_c,
  input logic [2:0] st,
  input logic [AW-1:0] ptr,
  input logic sda_oe
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_DEV  = 3'd1;
  localparam logic [2:0] C_WADR = 3'd3;
  localparam logic [2:0] C_RACK = 3'd7;

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == C_DEV) && !sda_oe);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == C_IDLE) && !sda_oe);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE) |-> !sda_oe);

  // R7
  ack_slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RACK) |-> !sda_oe);

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr) && ($past(st) != C_WADR)) |-> (ptr == $past(ptr) + 1'b1));

  // R9
  scl_low_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c),
  .stop_c(stop_c), .st(st), .ptr(ptr), .sda_oe(sda_oe)
);

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    16'h00A5, 16'hFF3C, 16'h30C3, 16'h319D,
    16'h4077, 16'h7F80, 16'h8001, 16'h55AA
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int checks = 0;
  int fails = 0;
  int hi_changes = 0;
  logic oe_prev = 1'b0;

  assign sda_line = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  i2c_mem_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== oe_prev)) hi_changes++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1;
    repeat (5) @(negedge clk);
    ack = ~sda_line;
    repeat (5) @(negedge clk);
    scl = 1'b0; wq();
  endtask

  task automatic recv(input logic ack_m, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1;
      repeat (5) @(negedge clk);
      b[i] = sda_line;
      repeat (5) @(negedge clk);
      scl = 1'b0;
    end
    wq(); sda_m = ~ack_m; wq(); scl = 1'b1; wq(); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input int n);
    logic ack;
    bus_start();
    send(DEV_W, ack); chk("R2 device ack on write", {7'd0, ack}, 8'd1);
    send(a, ack);     chk("R3 word address ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      send(d[8*k +: 8], ack); chk("R3 data ack", {7'd0, ack}, 8'd1);
    end
    bus_stop();
  endtask

  task automatic rd_body(input int n, output logic [31:0] got);
    logic [7:0] b;
    got = '0;
    for (int k = 0; k < n; k++) begin
      recv(k != n - 1, b);
      got[8*k +: 8] = b;
    end
    chk("R7 SDA released after NACK", {7'd0, sda_oe}, 8'd0);
    bus_stop();
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n, output logic [31:0] got);
    logic ack;
    bus_start();
    send(DEV_W, ack); chk("R5 device ack", {7'd0, ack}, 8'd1);
    send(a, ack);     chk("R5 word address ack", {7'd0, ack}, 8'd1);
    bus_start();
    send(DEV_R, ack); chk("R5 read ack after repeated START", {7'd0, ack}, 8'd1);
    rd_body(n, got);
  endtask

  task automatic rd_cur(input int n, output logic [31:0] got);
    logic ack;
    bus_start();
    send(DEV_R, ack); chk("R6 device ack on read", {7'd0, ack}, 8'd1);
    rd_body(n, got);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic ack;
    repeat (5) @(negedge clk);
    chk("R10 SDA released in reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][15:8], {24'd0, VEC[v][7:0]}, 1);
      rd_rand(VEC[v][15:8], 1, got);
      chk("R3 R5 R9 table byte", got[7:0], VEC[v][7:0]);
    end

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 SDA released by reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_cur(1, got);
    chk("R10 pointer cleared, array kept", got[7:0], 8'hA5);

    wr(8'h10, 32'h44332211, 4);
    rd_rand(8'h10, 3, got);
    chk("R7 sequential byte 0", got[7:0], 8'h11);
    chk("R7 sequential byte 1", got[15:8], 8'h22);
    chk("R7 sequential byte 2", got[23:16], 8'h33);
    rd_cur(1, got);
    chk("R6 current read after read", got[7:0], 8'h44);

    wr(8'h7F, {24'd0, 8'h81}, 1);
    rd_cur(1, got);
    chk("R6 current read after write", got[7:0], 8'h01);

    bus_start();
    send(DEV_W, ack);
    send(8'h40, ack);
    bus_stop();
    rd_cur(1, got);
    chk("R4 R1 address-only write then STOP", got[7:0], 8'h77);
    rd_rand(8'h40, 1, got);
    chk("R4 dummy write left byte intact", got[7:0], 8'h77);

    bus_start();
    send(8'hA2, ack); chk("R2 mismatched address NACK", {7'd0, ack}, 8'd0);
    send(8'h30, ack); chk("R2 ignored byte NACK", {7'd0, ack}, 8'd0);
    send(8'hEE, ack); chk("R2 ignored data NACK", {7'd0, ack}, 8'd0);
    bus_stop();
    rd_rand(8'h30, 1, got);
    chk("R2 memory untouched after mismatch", got[7:0], 8'hC3);

    bus_start();
    send(DEV_W, ack);
    send(8'h55, ack);
    bus_start();
    send(DEV_R, ack); chk("R1 repeated START restarts addressing", {7'd0, ack}, 8'd1);
    rd_body(1, got);
    chk("R1 byte after repeated START", got[7:0], 8'hAA);

    wr(8'hFE, 32'h007C6B5A, 3);
    rd_rand(8'hFE, 3, got);
    chk("R8 byte at 0xFE", got[7:0], 8'h5A);
    chk("R8 byte at 0xFF", got[15:8], 8'h6B);
    chk("R8 byte at 0x00 after wrap", got[23:16], 8'h7C);
    rd_rand(8'hFF, 2, got);
    chk("R8 read wrap byte 0xFF", got[7:0], 8'h6B);
    chk("R8 read wrap byte 0x00", got[15:8], 8'h7C);

    checks++;
    if (hi_changes != 0) begin
      fails++;
      $display("FAIL R9 SDA changed with SCL high actual=%0d expected=0", hi_changes);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule